// File: doc/BRIEF.md
# Programmable PWM Timer Channel

This block is one timer channel built around a 16-bit up-counter. A clock prescaler feeds the counter. It can divide the system clock, or it can count edges of an external clock input after synchronizing that input. Two compare registers watch the counter. Software picks which of them clears the counter, and that register sets the period. The other register sets the duty. Each compare register has its own output-compare setting: an enable, a level to load when counting starts, and a level to drive when that register matches. Together these form a single PWM waveform on one output pin.

Software reaches the channel through a simple register bus. A write is taken on a clock edge and a read is combinational. Software configures the prescaler, the edge choice, the clear source, the output settings and the two compare values. It then selects PWM operation through the mode register and sets the run bit.

A three-state controller sequences the output. The states are STOP (halted), FREE (counting in a non-PWM mode) and PWM (counting with the output driven).
- GO_PWM takes STOP to PWM when the run bit is set and the mode selects PWM. The output loads its initial level on this transition.
- GO_FREE takes STOP to FREE when the run bit is set and the mode does not select PWM.
- ENTER_PWM takes FREE to PWM when the mode becomes PWM while running. The initial level is not reloaded.
- LEAVE_PWM takes PWM to FREE when the mode stops selecting PWM.
- HALT takes FREE or PWM back to STOP when the run bit is cleared.

Top module: `pwm_timer_chan`

## Requirements
- R1: Prescaler codes 0, 1, 2 and 3 make the counter advance once every 1, 4, 16 and 64 system clocks while running.
- R2: Prescaler codes 4 to 7 count the external clock after a two-flop synchronizer. The edge field selects the counted edge: 0 counts rising edges, 1 counts falling edges, and 2 or 3 counts both edges.
- R3: The clear field selects the clear source. Code 1 makes a register-A match reset the counter to zero, and code 2 makes a register-B match do so. Code 0 and codes 3 to 7 never clear the counter, so it counts past both compare values.
- R4: With period value P in the clearing register and duty value D below P in the other register, the cycle lasts P+1 counts. The output takes the duty register's match level when the counter equals D, and the clearing register's match level when the counter equals P. The output changes on the same clock edge that advances the counter.
- R5: A compare register whose output-compare enable is 0 never changes the output when it matches.
- R6: When counting starts in PWM mode (state STOP with the run bit at 1), the output loads the clearing register's initial level one clock after the run bit is written. When the clear code is not 2, register A's initial level is used.
- R7: Only mode value 2 selects PWM operation. In any other mode the counter still runs, but the output holds its value.
- R8: Clearing the run bit stops the counter and keeps its value. The counter register can be written and read back.
- R9: If the duty value is greater than the period value, the duty match never occurs and the output keeps the period-match level. If both matches occur in the same count, the clearing register's level wins, so D equal to P gives a constant period-match level.
- R10: The register map is as follows. Registers read back their fields, with unused bits reading zero, and all registers reset to zero.

| Address | Contents |
|---|---|
| 0 | Control: bits 2:0 prescaler, bits 4:3 edge, bits 7:5 clear source |
| 1 | Mode: bits 3:0 |
| 2 | Output settings: register A enable in bit 0, initial level in bit 1, match level in bit 2; register B enable in bit 4, initial level in bit 5, match level in bit 6 |
| 3 | Run bit: bit 0 |
| 4 | Counter |
| 5 | Compare A |
| 6 | Compare B |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| ext_clk | input | 1 | External count clock, asynchronous to clk |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check on every cycle that a clearing match zeroes the counter, that an uncleared tick adds exactly one, that the counter holds when no tick arrives, and that a divide-by-four prescaler never ticks on two cycles in a row. They also check that the output loads its initial level on GO_PWM, that it never moves in FREE, and that the clearing level wins when both matches coincide. Only the bench scenarios can show the measured period and high time for each prescaler and external-edge setting, duty 0, duty equal to and above the period, a clear from register B, the never-clear case, and register readback.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_MODE   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_OUTCFG = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_RUN    = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] ADDR_CMPA   = 3'd5;
    localparam logic [REG_ADDR_W-1:0] ADDR_CMPB   = 3'd6;

    localparam logic [3:0] MODE_PWM  = 4'd2;
    localparam logic [2:0] CLR_BY_A  = 3'd1;
    localparam logic [2:0] CLR_BY_B  = 3'd2;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_FREE = 2'd1,
        ST_PWM  = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic en;
        logic init;
        logic lvl;
    } oc_cfg_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] presc,
    input  logic [1:0] edge_sel,
    input  logic       ext_clk,
    output logic       tick
);

    logic [DIV_W-1:0] div_cnt_q;
    logic             ext_s1_q, ext_s2_q, ext_prev_q;
    logic             int_tick, ext_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt_q  <= '0;
            ext_s1_q   <= 1'b0;
            ext_s2_q   <= 1'b0;
            ext_prev_q <= 1'b0;
        end else begin
            div_cnt_q  <= run ? div_cnt_q + 1'b1 : '0;
            ext_s1_q   <= ext_clk;
            ext_s2_q   <= ext_s1_q;
            ext_prev_q <= ext_s2_q;
        end
    end

    // Divide by 4**code: tick when the low 2*code divider bits are all ones.
    always_comb begin
        int_tick = 1'b1;
        for (int b = 0; b < DIV_W; b++) begin
            if (b < 2 * int'(presc[1:0])) begin
                int_tick = int_tick & div_cnt_q[b];
            end
        end
    end

    always_comb begin
        case (edge_sel)
            2'd0:    ext_tick = ext_s2_q & ~ext_prev_q;
            2'd1:    ext_tick = ~ext_s2_q & ext_prev_q;
            default: ext_tick = ext_s2_q ^ ext_prev_q;
        endcase
    end

    assign tick = run & (presc[2] ? ext_tick : int_tick);

    assert_div4_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc == 3'd1) |=> !(tick && presc == 3'd1));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [2:0]       clr_sel,
    output logic [CNT_W-1:0] count,
    output logic             match_a,
    output logic             match_b
);
    import pwm_pkg::*;

    logic [CNT_W-1:0] count_q;
    logic             clr_hit;

    assign match_a = tick && (count_q == cmp_a);
    assign match_b = tick && (count_q == cmp_b);

    always_comb begin
        case (clr_sel)
            CLR_BY_A: clr_hit = match_a;
            CLR_BY_B: clr_hit = match_b;
            default:  clr_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (cnt_wr)  count_q <= cnt_wdata;
        else if (clr_hit) count_q <= '0;
        else if (tick)    count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !cnt_wr) |=> (count_q == '0));

    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_hit && !cnt_wr) |=> (count_q == $past(count_q) + 1'b1));

    assert_hold_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count_q));

endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  logic    pwm_mode,
    input  logic    clr_is_b,
    input  logic    match_a,
    input  logic    match_b,
    input  oc_cfg_t oc_a,
    input  oc_cfg_t oc_b,
    output logic    pwm_out
);

    chan_state_e state_q, state_d;
    logic        pwm_q;
    logic        per_hit, duty_hit, per_lvl, duty_lvl, init_lvl;

    // Role of each compare register follows the clear source.
    always_comb begin
        if (clr_is_b) begin
            per_hit  = match_b & oc_b.en;
            per_lvl  = oc_b.lvl;
            init_lvl = oc_b.init;
            duty_hit = match_a & oc_a.en;
            duty_lvl = oc_a.lvl;
        end else begin
            per_hit  = match_a & oc_a.en;
            per_lvl  = oc_a.lvl;
            init_lvl = oc_a.init;
            duty_hit = match_b & oc_b.en;
            duty_lvl = oc_b.lvl;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run) state_d = pwm_mode ? ST_PWM : ST_FREE;   // GO_PWM / GO_FREE
            ST_FREE: begin
                if (!run)          state_d = ST_STOP;                  // HALT
                else if (pwm_mode) state_d = ST_PWM;                   // ENTER_PWM
            end
            ST_PWM: begin
                if (!run)           state_d = ST_STOP;                 // HALT
                else if (!pwm_mode) state_d = ST_FREE;                 // LEAVE_PWM
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            case (state_q)
                ST_STOP: if (run && pwm_mode) pwm_q <= init_lvl;
                ST_PWM: begin
                    if (run && pwm_mode) begin
                        if (per_hit)       pwm_q <= per_lvl;
                        else if (duty_hit) pwm_q <= duty_lvl;
                    end
                end
                default: ;
            endcase
        end
    end

    assign pwm_out = pwm_q;

    assert_start_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && run && pwm_mode) |=> (pwm_q == $past(init_lvl)));

    assert_free_static_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE) |=> $stable(pwm_q));

    assert_period_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWM && run && pwm_mode && per_hit && duty_hit)
        |=> (pwm_q == $past(per_lvl)));

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_clk,
    output logic             pwm_out
);
    import pwm_pkg::*;

    localparam int CTRL_W = 8;

    logic [2:0]       presc_q;
    logic [1:0]       edge_q;
    logic [2:0]       clr_q;
    logic [3:0]       mode_q;
    oc_cfg_t          oc_a_q, oc_b_q;
    logic             run_q;
    logic [CNT_W-1:0] cmp_a_q, cmp_b_q;
    logic [CNT_W-1:0] count;
    logic             tick, match_a, match_b, cnt_wr;

    assign cnt_wr = bus_wr && (bus_addr == ADDR_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            edge_q  <= '0;
            clr_q   <= '0;
            mode_q  <= '0;
            oc_a_q  <= '0;
            oc_b_q  <= '0;
            run_q   <= 1'b0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    presc_q <= bus_wdata[2:0];
                    edge_q  <= bus_wdata[4:3];
                    clr_q   <= bus_wdata[7:5];
                end
                ADDR_MODE:   mode_q <= bus_wdata[3:0];
                ADDR_OUTCFG: begin
                    oc_a_q <= '{en: bus_wdata[0], init: bus_wdata[1], lvl: bus_wdata[2]};
                    oc_b_q <= '{en: bus_wdata[4], init: bus_wdata[5], lvl: bus_wdata[6]};
                end
                ADDR_RUN:  run_q   <= bus_wdata[0];
                ADDR_CMPA: cmp_a_q <= bus_wdata;
                ADDR_CMPB: cmp_b_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:   bus_rdata[CTRL_W-1:0] = {clr_q, edge_q, presc_q};
            ADDR_MODE:   bus_rdata[3:0] = mode_q;
            ADDR_OUTCFG: bus_rdata[6:0] = {oc_b_q.lvl, oc_b_q.init, oc_b_q.en, 1'b0,
                                           oc_a_q.lvl, oc_a_q.init, oc_a_q.en};
            ADDR_RUN:    bus_rdata[0] = run_q;
            ADDR_COUNT:  bus_rdata = count;
            ADDR_CMPA:   bus_rdata = cmp_a_q;
            ADDR_CMPB:   bus_rdata = cmp_b_q;
            default: ;
        endcase
    end

    pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .presc    (presc_q),
        .edge_sel (edge_q),
        .ext_clk  (ext_clk),
        .tick     (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (bus_wdata),
        .cmp_a     (cmp_a_q),
        .cmp_b     (cmp_b_q),
        .clr_sel   (clr_q),
        .count     (count),
        .match_a   (match_a),
        .match_b   (match_b)
    );

    pwm_out_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .pwm_mode (mode_q == MODE_PWM),
        .clr_is_b (clr_q == CLR_BY_B),
        .match_a  (match_a),
        .match_b  (match_b),
        .oc_a     (oc_a_q),
        .oc_b     (oc_b_q),
        .pwm_out  (pwm_out)
    );

endmodule

// File: tb/tb_pwm_timer_chan.sv
module tb_pwm_timer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int ext_half = 0;
    bit done = 1'b0;

    typedef struct {
        int    window;
        int    exp_high;
        int    exp_rises;
        string req;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    pwm_timer_chan dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_clk   (ext_clk),
        .pwm_out   (pwm_out)
    );

    // External clock: toggles every ext_half system clocks when enabled.
    initial begin
        forever begin
            @(negedge clk);
            if (ext_half > 0) begin
                repeat (ext_half - 1) @(negedge clk);
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d[15:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    // Scoreboard monitor: measures high time and rising edges over a window.
    initial begin
        forever begin
            exp_t it;
            int hi;
            int rises;
            logic prev;
            while (sbq.size() == 0) @(negedge clk);
            it = sbq[0];
            hi = 0;
            rises = 0;
            prev = pwm_out;
            for (int i = 0; i < it.window; i++) begin
                @(negedge clk);
                if (pwm_out) hi++;
                if (pwm_out && !prev) rises++;
                prev = pwm_out;
            end
            check({it.req, " high time"}, hi == it.exp_high, hi, it.exp_high);
            check({it.req, " period count"}, rises == it.exp_rises, rises, it.exp_rises);
            void'(sbq.pop_front());
        end
    end

    task automatic push_exp(input string req, input int window, input int high, input int k);
        exp_t it;
        it.req = req;
        it.window = window;
        it.exp_high = high;
        it.exp_rises = (high > 0 && high < window) ? k : 0;
        sbq.push_back(it);
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // Programs one PWM setting and queues the expected measurement.
    task automatic pwm_case(input string req, input int presc, input int edge_code,
                            input int clr, input int cmpa, input int cmpb, input int outcfg,
                            input int n, input int per, input int duty, input int k);
        int high;
        wr(3'd3, 0);
        wr(3'd0, presc | (edge_code << 3) | (clr << 5));
        wr(3'd5, cmpa);
        wr(3'd6, cmpb);
        wr(3'd2, outcfg);
        wr(3'd4, 0);
        wr(3'd1, 2);
        wr(3'd3, 1);
        repeat (2 * (per + 1) * n + 8) @(negedge clk);
        high = (duty < per) ? (per - duty) * n * k : 0;
        push_exp(req, k * (per + 1) * n, high, k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int c1;
        int c2;
        int lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state and readback
        check("R10 reset output", pwm_out == 1'b0, int'(pwm_out), 0);
        rd(3'd4, v); check("R10 reset counter", v == 0, v, 0);
        rd(3'd5, v); check("R10 reset compare A", v == 0, v, 0);
        wr(3'd0, 8'hB5);
        rd(3'd0, v); check("R10 control readback", v == 16'h00B5, v, 16'h00B5);
        wr(3'd2, 16'hFFFF);
        rd(3'd2, v); check("R10 output settings readback", v == 16'h0077, v, 16'h0077);

        // OUTCFG 0x51: A en, A init 0, A lvl 0; B en, B lvl 1
        pwm_case("R4 R1 div1 P9 D3",        0, 0, 1, 9, 3, 16'h51, 1, 9, 3, 4);
        pwm_case("R1 div4 P7 D2",           1, 0, 1, 7, 2, 16'h51, 4, 7, 2, 3);
        pwm_case("R1 div16 P3 D1",          2, 0, 1, 3, 1, 16'h51, 16, 3, 1, 2);
        pwm_case("R1 R4 div64 duty0 P3 D0", 3, 0, 1, 3, 0, 16'h51, 64, 3, 0, 2);
        pwm_case("R9 duty equals period",   0, 0, 1, 6, 6, 16'h51, 1, 6, 6, 4);
        pwm_case("R3 clear by B P11 D4",    0, 0, 2, 4, 11, 16'h15, 1, 11, 4, 3);

        ext_half = 5;
        pwm_case("R2 external rising",      4, 0, 1, 4, 1, 16'h51, 10, 4, 1, 3);
        pwm_case("R2 external falling",     5, 1, 1, 4, 1, 16'h51, 10, 4, 1, 3);
        pwm_case("R2 external both edges",  6, 2, 1, 4, 1, 16'h51, 5, 4, 1, 3);
        ext_half = 0;

        pwm_case("R9 duty above period",    0, 0, 1, 5, 9, 16'h51, 1, 5, 9, 4);

        // R6: initial level loads one clock after the run write
        wr(3'd3, 0);
        check("R6 output low before start", pwm_out == 1'b0, int'(pwm_out), 0);
        wr(3'd5, 50);
        wr(3'd6, 40);
        wr(3'd4, 0);
        wr(3'd2, 16'h53);
        wr(3'd3, 1);
        check("R6 no load on write edge", pwm_out == 1'b0, int'(pwm_out), 0);
        @(negedge clk);
        check("R6 initial level loaded", pwm_out == 1'b1, int'(pwm_out), 1);

        // R8: halt keeps the counter, counter write/read
        wr(3'd3, 0);
        rd(3'd4, c1);
        repeat (20) @(negedge clk);
        rd(3'd4, c2);
        check("R8 counter held while halted", c1 == c2 && c1 != 0, c2, c1);
        wr(3'd4, 1234);
        rd(3'd4, v);
        check("R8 counter write readback", v == 1234, v, 1234);

        // R7: non-PWM mode keeps output static while counting
        wr(3'd0, 0);
        wr(3'd5, 3);
        wr(3'd6, 1);
        wr(3'd4, 0);
        wr(3'd1, 0);
        wr(3'd3, 1);
        rd(3'd4, c1);
        lvl = int'(pwm_out);
        push_exp("R7 static in non-PWM mode", 40, lvl * 40, 0);
        rd(3'd4, c2);
        check("R7 counter runs in non-PWM mode", c2 > c1 + 30, c2, c1 + 41);

        // R3 R5: never clear, A compare disabled
        wr(3'd3, 0);
        wr(3'd0, 0);
        wr(3'd5, 10);
        wr(3'd6, 5);
        wr(3'd2, 16'h50);
        wr(3'd4, 0);
        wr(3'd1, 2);
        wr(3'd3, 1);
        repeat (40) @(negedge clk);
        rd(3'd4, v);
        check("R3 counter passes both compares", v > 30, v, 41);
        check("R5 disabled A match leaves output", pwm_out == 1'b1, int'(pwm_out), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule